// File: doc/BRIEF.md
# Redundant-Range Modular Adder/Subtractor for the 224-bit NIST-Style Prime

This block adds or subtracts two 224-bit field elements modulo p = 2^224 − 2^96 + 1. Operands and results lie in the redundant range [0, 2^224). The block does not reduce fully into [0, p), so a result may equal a value in [p, 2^224). A downstream multiplier or adder can take such a result as an operand without any comparison step.

The reduction never subtracts the modulus. It uses the identity 2^224 ≡ 2^96 − 1 (mod p). Any excess above bit 223 is taken as a small count t and replaced by t·(2^96 − 1). The limbs of that constant are built from t with masks, not from a table. For subtraction, a bias of 2p is added first, so the raw value is never negative and t stays in {0, 1, 2}.

If the fold itself carries past bit 223, a second fold of the same kind follows. After that second fold the value is always below 2^224. The result is registered, so it appears one clock after the operands are presented.

Top module: `p224_redundant_addsub`

## Requirements
- R1: With op_sub = 0, result ≡ a + b (mod p), and result < 2^224.
- R2: With op_sub = 1, result ≡ a − b (mod p), and result < 2^224.
- R3: out_valid is high exactly in the cycle after a cycle with in_valid high. The matching result is on the port in that same cycle.
- R4: While in_valid is low, result keeps its last value.
- R5: In reset, out_valid is 0 and result is 0.
- R6: When one fold is not enough, a second fold is applied. For a = b = 2^224 − 1 with add, the result is 2^97 − 4. For a = 2^96 − 1, b = 0 with subtract, the result is 2^96 − 1.
- R7: Subtraction is biased by 2p. For a = 0 and b = 2^224 − 1 the result is 2^224 − 2^97 + 3. For a = b the result is exactly p. For a = 2^224 − 1, b = 0 the top count is 2 and the result is 2^224 − 1.
- R8: The result is the largest value below 2^224 that is congruent to the raw value and not above it. The raw value is a + b for add and 2p + a − b for subtract. The second fold never produces a further carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op_sub are valid this cycle |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| a | input | 224 | First operand, in [0, 2^224) |
| b | input | 224 | Second operand, in [0, 2^224) |
| out_valid | output | 1 | result carries a new value |
| result | output | 224 | Redundant-range result |

## Verification
The bench builds the block with its default limb parameters: 32-bit limbs, seven limbs per operand, and the fold boundary three limbs up. This matches the 224-bit prime exactly, so expected values can be stated in closed form.

At these values, directed operands reach every fold path. These include the add case that needs a second fold, subtraction with a top count of 0, 1 and 2, and the rare subtract window [2^96 − 1, 2^97 − 3] for a − b, where the first fold carries.

Random operands, biased towards all-ones upper limbs, check the exact redundant value against a subtract-p-until-below-2^224 model.

// File: rtl/p224_addsub_pkg.sv
package p224_addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/p224_prebias.sv
// Raw sum a + b, or 2p + a - b, as a two-bit-wide excess above W bits.
module p224_prebias #(
    parameter int W = 224,
    parameter int K = 96
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         op_sub,
    output logic [W+1:0] raw
);
    localparam logic [W+1:0] ONE_X = {{(W+1){1'b0}}, 1'b1};
    localparam logic [W+1:0] TWO_P = (ONE_X << (W + 1)) - (ONE_X << (K + 1)) + (ONE_X << 1);

    logic [W+1:0] sel_mask;
    logic [W+1:0] b_term;
    logic [W+1:0] bias;

    always_comb begin
        sel_mask = {(W+2){op_sub}};
        // Two's complement of b when subtracting: invert here, +1 below.
        b_term   = {2'b00, b} ^ sel_mask;
        bias     = TWO_P & sel_mask;
        raw      = {2'b00, a} + bias + b_term + {{(W+1){1'b0}}, op_sub};
    end

endmodule

// File: rtl/p224_fold_const.sv
// Limbs of t*(2^K - 1) for t in 0..3, built from masks only.
module p224_fold_const #(
    parameter int W  = 224,
    parameter int K  = 96,
    parameter int LW = 32
) (
    input  logic [1:0]   t,
    output logic [W-1:0] k
);
    localparam int NL = W / LW;
    localparam int FL = K / LW;

    logic          nz;
    logic [LW-1:0] t_ext;
    logic [LW-1:0] nz_mask;

    assign nz      = |t;
    assign t_ext   = {{(LW-2){1'b0}}, t};
    assign nz_mask = {LW{nz}};

    for (genvar i = 0; i < NL; i++) begin : g_limb
        if (i == 0) begin : g_low
            assign k[i*LW +: LW] = '0 - t_ext;
        end else if (i < FL) begin : g_mid
            assign k[i*LW +: LW] = nz_mask;
        end else if (i == FL) begin : g_top
            assign k[i*LW +: LW] = (t_ext - {{(LW-1){1'b0}}, 1'b1}) & nz_mask;
        end else begin : g_zero
            assign k[i*LW +: LW] = '0;
        end
    end

endmodule

// File: rtl/p224_fold.sv
// One fold step: low + t*(2^K - 1), with carry past bit W-1.
module p224_fold #(
    parameter int W  = 224,
    parameter int K  = 96,
    parameter int LW = 32
) (
    input  logic [W-1:0] low,
    input  logic [1:0]   t,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W-1:0] kconst;
    logic [W:0]   full;

    p224_fold_const #(.W(W), .K(K), .LW(LW)) u_const (
        .t (t),
        .k (kconst)
    );

    always_comb begin
        full  = {1'b0, low} + {1'b0, kconst};
        sum   = full[W-1:0];
        carry = full[W];
    end

endmodule

// File: rtl/p224_redundant_addsub.sv
module p224_redundant_addsub
    import p224_addsub_pkg::*;
#(
    parameter int LIMB_W     = 32,
    parameter int N_LIMBS    = 7,
    parameter int FOLD_LIMBS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      op_sub,
    input  logic [LIMB_W*N_LIMBS-1:0] a,
    input  logic [LIMB_W*N_LIMBS-1:0] b,
    output logic                      out_valid,
    output logic [LIMB_W*N_LIMBS-1:0] result
);
    localparam int W = LIMB_W * N_LIMBS;
    localparam int K = LIMB_W * FOLD_LIMBS;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    logic [W+1:0] raw;
    logic [W-1:0] fold1_sum, fold2_sum;
    logic         fold1_carry, fold2_carry;

    p224_prebias #(.W(W), .K(K)) u_prebias (
        .a      (a),
        .b      (b),
        .op_sub (op_sub),
        .raw    (raw)
    );

    p224_fold #(.W(W), .K(K), .LW(LIMB_W)) u_fold1 (
        .low   (raw[W-1:0]),
        .t     (raw[W+1:W]),
        .sum   (fold1_sum),
        .carry (fold1_carry)
    );

    p224_fold #(.W(W), .K(K), .LW(LIMB_W)) u_fold2 (
        .low   (fold1_sum),
        .t     ({1'b0, fold1_carry}),
        .sum   (fold2_sum),
        .carry (fold2_carry)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = fold2_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R3
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R4
    AST_ADD_EXCESS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sub == OP_ADD) |-> !raw[W+1]); // R1
    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fold1_carry) |-> (raw[W+1:W] != 2'b00)); // R6
    AST_NO_THIRD_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !fold2_carry); // R8

endmodule

// File: tb/p224_redundant_addsub_tb.sv
module p224_redundant_addsub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW  = 32;
    localparam int NL  = 7;
    localparam int W   = LW * NL;
    localparam logic [255:0] ONE  = 256'd1;
    localparam logic [255:0] TOP  = ONE << W;
    localparam logic [255:0] PMOD = (ONE << 224) - (ONE << 96) + ONE;
    localparam logic [W-1:0] MAXV = '1;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    item_t sb[$];
    logic [W-1:0] last_res = '0;
    bit    seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    p224_redundant_addsub u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sub    (op_sub),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .result    (result)
    );

    // Model from R8: subtract p until the raw value drops below 2^224.
    function automatic logic [W-1:0] ref_val(logic [W-1:0] x, logic [W-1:0] y, bit sub);
        logic [255:0] v;
        if (sub) v = (PMOD << 1) + {32'd0, x} - {32'd0, y};
        else     v = {32'd0, x} + {32'd0, y};
        for (int i = 0; i < 4; i++) begin
            if (v >= TOP) v = v - PMOD;
        end
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] rnd_op(int mode);
        logic [W-1:0] v;
        for (int i = 0; i < NL; i++) begin
            v[i*LW +: LW] = $urandom;
        end
        if (mode == 1) v[W-1 -: 4*LW] = '1;
        if (mode == 2) v[W-1 : 3*LW] = '0;
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [W-1:0] x, logic [W-1:0] y, bit sub, logic [W-1:0] exp, string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op_sub   = sub;
        a        = x;
        b        = y;
        it.exp   = exp;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a        = rnd_op(0);
            b        = rnd_op(0);
            op_sub   = $urandom_range(0, 1);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected out_valid", result, '0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(result == it.exp, it.tag, result, it.exp);
                end
                last_res = result;
                seen     = 1'b1;
            end else if (seen) begin
                check(result == last_res, "R4 hold while idle", result, last_res);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R5 reset out_valid", {{(W-1){1'b0}}, out_valid}, '0);
        check(result == '0, "R5 reset result", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        drive(MAXV, MAXV, 1'b1 ^ 1'b1, W'((ONE << 97) - 4), "R6 add second fold max+max");
        drive(W'((ONE << 96) - 1), '0, 1'b1, W'((ONE << 96) - 1), "R6 sub second fold");
        idle(1);
        drive('0, MAXV, 1'b1, W'(TOP - (ONE << 97) + 3), "R7 sub 0-max");
        drive(W'(256'h1234_5678_9abc), W'(256'h1234_5678_9abc), 1'b1, W'(PMOD), "R7 sub equal gives p");
        drive(MAXV, '0, 1'b1, MAXV, "R7 sub excess two");
        drive('0, '0, 1'b0, '0, "R1 add zero");
        drive(MAXV, W'(1), 1'b0, W'((ONE << 96) - 1), "R1 add single fold");
        idle(3);

        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] x, y;
            bit s;
            x = rnd_op(n % 3);
            y = rnd_op((n / 3) % 3);
            s = n[0];
            drive(x, y, s, ref_val(x, y, s), s ? "R2 random sub" : "R1 random add");
            if ((n % 7) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        check(sb.size() == 0, "R3 all results delivered", W'(sb.size()), '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule